// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA Channel

This block is one bus-mastering playback channel for 16-bit PCM audio. Software places a ring of 32 buffer descriptors in memory, writes the ring's base address into the channel and sets the run bit. The channel reads each descriptor (a buffer address word followed by a length word), fetches the buffer's samples one at a time over a simple memory read port, and hands them in order to the audio link through a small sample buffer. The link takes a sample with a one-cycle strobe.

Progress is visible through a small register file: the index of the descriptor in use, a count of samples still to be fetched from it, a last-valid index that software moves around the ring to keep the stream alive, a status register with write-one-to-clear flags, and a control register with run, interrupt enables and a self-clearing channel reset. When the channel finishes the descriptor at the last-valid index it flags this and stops fetching until software moves the last-valid index on. A single interrupt line reports any enabled status flag.

Top module: `adma_ring_channel`

## Requirements
- R1: After rst_n is released, every readable register reads 0, irq is 0, mem_req is 0 and smp_valid is 0.
- R2: Once running, the channel reads the descriptor at ring index i with two requests: first at base + 8*i (buffer byte address, bit 0 ignored), then at base + 8*i + 4 (length word: bits 15:0 are the sample count, bit 31 asks for a completion flag).
- R3: Samples of a descriptor are read at buffer address + 2*k for k = 0 up to count-1; each read returns a 32-bit word whose bits 15:0 hold the sample when address bit 1 is 0 and bits 31:16 when it is 1; samples appear on smp_data in that order, and the remaining count (register 4) drops by one per sample read.
- R4: The current index (register 1) changes only when the next descriptor's length word is loaded, advancing by one and wrapping from 31 to 0.
- R5: Completing a descriptor whose length bit 31 is set sets status bit 1; completing one with bit 31 clear leaves status bit 1 unchanged.
- R6: Completing the descriptor whose index equals the last-valid index (register 2) sets status bit 2, after which no memory request is made until the last-valid index is changed; the channel then continues with the following ring index.
- R7: A descriptor with a sample count of 0 completes without any sample read.
- R8: Writing register 3 clears each status bit written as 1 and leaves bits written as 0; a status bit never clears otherwise except by channel reset.
- R9: irq is 1 exactly when some status bit is 1 and its enable is set (status bit 0 with control bit 1, bit 1 with control bit 2, bit 2 with control bit 3).
- R10: With control bit 0 (run) clear, the channel makes no memory request; setting it again resumes where it left off.
- R11: A strobe on smp_strobe while no sample is held and run is set sets status bit 0 (sample underrun); with run clear the same strobe has no effect.
- R12: Writing control bit 4 resets the channel: current index, last-valid index, remaining count, status and the whole control register become 0 and held samples are dropped; the bit reads back 0 again two cycles after the write.
- R13: Register selects are 0 base address (32 bits, read/write), 1 current index (read only), 2 last-valid index (read/write), 3 status, 4 remaining count (read only), 5 control; the base address survives a channel reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the read |
| mem_ack | input | 1 | Read accepted; mem_rdata valid in this cycle |
| mem_rdata | input | 32 | Read data word |
| smp_strobe | input | 1 | Link takes one sample |
| smp_valid | output | 1 | A sample is held for the link |
| smp_data | output | 16 | Oldest held sample |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle the assertions watch that the current index only steps by one or returns to zero, that the remaining count only rises on a length-word load, that a halted or paused channel issues no request, that the sample buffer never takes a push when full, that status bits clear only through a write or a reset, and that the reset bit clears itself. What only the scenarios can show is the data path itself: the exact sample order across descriptors with odd half-word starts and a zero-length entry, the index wrap past 31, the completion flags following each descriptor's request bit, the underrun flag depending on run, and the full effect of a mid-stream channel reset.

// File: rtl/adma_pkg.sv
package adma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FADDR = 3'd1,
        ST_FLEN  = 3'd2,
        ST_XFER  = 3'd3,
        ST_DONE  = 3'd4,
        ST_HALT  = 3'd5
    } eng_state_e;

    localparam logic [2:0] SEL_BASE = 3'd0;
    localparam logic [2:0] SEL_CIDX = 3'd1;
    localparam logic [2:0] SEL_LVI  = 3'd2;
    localparam logic [2:0] SEL_STAT = 3'd3;
    localparam logic [2:0] SEL_REM  = 3'd4;
    localparam logic [2:0] SEL_CTRL = 3'd5;

    localparam int STAT_W = 3;
    localparam int LEN_FLAG_BIT = 31;

    typedef struct packed {
        logic rst;
        logic ie_lv;
        logic ie_bc;
        logic ie_fe;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/adma_fifo.sv
module adma_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         valid,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t r_q, r_d;
    logic  do_pop;

    assign head  = r_q.mem[r_q.rd];
    assign valid = (r_q.cnt != '0);
    assign full  = (r_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        r_d    = r_q;
        do_pop = pop && valid;
        if (flush) begin
            r_d.wr  = '0;
            r_d.rd  = '0;
            r_d.cnt = '0;
        end else begin
            if (push) begin
                r_d.mem[r_q.wr] = push_data;
                r_d.wr          = (r_q.wr == PTR_W'(DEPTH - 1)) ? '0 : r_q.wr + 1'b1;
            end
            if (do_pop) begin
                r_d.rd = (r_q.rd == PTR_W'(DEPTH - 1)) ? '0 : r_q.rd + 1'b1;
            end
            r_d.cnt = r_q.cnt + CNT_W'(push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3: the engine never pushes into a full buffer
    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("push into full sample buffer");

endmodule

// File: rtl/adma_engine.sv
module adma_engine
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16,
    parameter int SMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  lvi,
    input  logic              fifo_full,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              push,
    output logic [SMP_W-1:0]  push_data,
    output logic [IDX_W-1:0]  civ,
    output logic [CNT_W-1:0]  rem,
    output logic              ev_bc,
    output logic              ev_lv
);
    localparam int DESC_SHIFT = 3;

    typedef struct packed {
        eng_state_e        state;
        logic [IDX_W-1:0]  nxt;
        logic [IDX_W-1:0]  civ;
        logic [CNT_W-1:0]  rem;
        logic [ADDR_W-1:0] bufp;
        logic              ioc;
    } eng_t;

    eng_t r_q, r_d;
    logic [ADDR_W-1:0] desc_addr;
    logic              hit;

    assign civ = r_q.civ;
    assign rem = r_q.rem;

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_addr  = '0;
        push      = 1'b0;
        push_data = r_q.bufp[1] ? mem_rdata[31:16] : mem_rdata[15:0];
        ev_bc     = 1'b0;
        ev_lv     = 1'b0;
        desc_addr = base + ADDR_W'({r_q.nxt, {DESC_SHIFT{1'b0}}});
        hit       = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (run) begin
                    r_d.nxt   = r_q.civ;
                    r_d.state = ST_FADDR;
                end
            end
            ST_FADDR: begin
                mem_req  = run;
                mem_addr = desc_addr;
                hit      = mem_req && mem_ack;
                if (hit) begin
                    r_d.bufp  = ADDR_W'(mem_rdata) & ~ADDR_W'(1);
                    r_d.state = ST_FLEN;
                end
            end
            ST_FLEN: begin
                mem_req  = run;
                mem_addr = desc_addr + ADDR_W'(4);
                hit      = mem_req && mem_ack;
                if (hit) begin
                    r_d.civ   = r_q.nxt;
                    r_d.rem   = mem_rdata[CNT_W-1:0];
                    r_d.ioc   = mem_rdata[LEN_FLAG_BIT];
                    r_d.state = (mem_rdata[CNT_W-1:0] == '0) ? ST_DONE : ST_XFER;
                end
            end
            ST_XFER: begin
                mem_req  = run && !fifo_full;
                mem_addr = r_q.bufp;
                hit      = mem_req && mem_ack;
                if (hit) begin
                    push     = 1'b1;
                    r_d.bufp = r_q.bufp + ADDR_W'(2);
                    r_d.rem  = r_q.rem - 1'b1;
                    if (r_q.rem == CNT_W'(1)) r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                ev_bc = r_q.ioc;
                if (r_q.civ == lvi) begin
                    ev_lv     = 1'b1;
                    r_d.state = ST_HALT;
                end else begin
                    r_d.nxt   = r_q.civ + 1'b1;
                    r_d.state = ST_FADDR;
                end
            end
            ST_HALT: begin
                if (lvi != r_q.civ) begin
                    r_d.nxt   = r_q.civ + 1'b1;
                    r_d.state = ST_FADDR;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (soft_rst) begin
            r_d     = '0;
            mem_req = 1'b0;
            push    = 1'b0;
            ev_bc   = 1'b0;
            ev_lv   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R4: the current index only steps by one around the ring or returns to zero
    assert_civ_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.civ) |-> (r_q.civ == IDX_W'($past(r_q.civ) + 1'b1)) || (r_q.civ == '0))
        else $error("current index jumped");

    // R3: the remaining count only grows when a length word is taken
    assert_rem_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rem > $past(r_q.rem)) |-> $past(r_q.state == ST_FLEN && mem_ack))
        else $error("remaining count rose without a length load");

    // R6: a halted channel issues no request
    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HALT) |-> !mem_req)
        else $error("request while halted at last-valid index");

endmodule

// File: rtl/adma_ring_channel.sv
module adma_ring_channel
    import adma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_LEN   = 32,
    parameter int CNT_W      = 16,
    parameter int SMP_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              smp_strobe,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic              irq
);
    localparam int IDX_W = $clog2(RING_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  lvi;
        logic [STAT_W-1:0] status;
        ctrl_t             ctrl;
    } regs_t;

    regs_t r_q, r_d;

    logic              fifo_full;
    logic              eng_push;
    logic [SMP_W-1:0]  eng_data;
    logic [IDX_W-1:0]  civ;
    logic [CNT_W-1:0]  rem;
    logic              ev_bc, ev_lv;
    logic              underrun;
    logic [STAT_W-1:0] w1c;

    adma_engine #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .SMP_W  (SMP_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (r_q.ctrl.rst),
        .run       (r_q.ctrl.run),
        .base      (r_q.base),
        .lvi       (r_q.lvi),
        .fifo_full (fifo_full),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .push      (eng_push),
        .push_data (eng_data),
        .civ       (civ),
        .rem       (rem),
        .ev_bc     (ev_bc),
        .ev_lv     (ev_lv)
    );

    adma_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SMP_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (r_q.ctrl.rst),
        .push      (eng_push),
        .push_data (eng_data),
        .pop       (smp_strobe),
        .head      (smp_data),
        .valid     (smp_valid),
        .full      (fifo_full)
    );

    always_comb begin
        r_d      = r_q;
        w1c      = '0;
        underrun = smp_strobe && !smp_valid && r_q.ctrl.run;
        if (r_q.ctrl.rst) begin
            r_d.lvi    = '0;
            r_d.status = '0;
            r_d.ctrl   = '0;
        end else begin
            if (reg_we) begin
                case (reg_sel)
                    SEL_BASE: r_d.base = reg_wdata[ADDR_W-1:0];
                    SEL_LVI:  r_d.lvi  = reg_wdata[IDX_W-1:0];
                    SEL_STAT: w1c      = reg_wdata[STAT_W-1:0];
                    SEL_CTRL: r_d.ctrl = ctrl_t'(reg_wdata[4:0]);
                    default: ;
                endcase
            end
            r_d.status = (r_q.status & ~w1c) | {ev_lv, ev_bc, underrun};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = |(r_q.status & {r_q.ctrl.ie_lv, r_q.ctrl.ie_bc, r_q.ctrl.ie_fe});

    always_comb begin
        case (reg_sel)
            SEL_BASE: reg_rdata = 32'(r_q.base);
            SEL_CIDX: reg_rdata = 32'(civ);
            SEL_LVI:  reg_rdata = 32'(r_q.lvi);
            SEL_STAT: reg_rdata = 32'(r_q.status);
            SEL_REM:  reg_rdata = 32'(rem);
            SEL_CTRL: reg_rdata = 32'(r_q.ctrl);
            default:  reg_rdata = '0;
        endcase
    end

    // R12: the channel reset bit clears itself
    assert_reset_selfclear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctrl.rst |=> !r_q.ctrl.rst)
        else $error("channel reset bit stuck");

    // R8: a status bit only drops through a write-one or a channel reset
    assert_status_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.status & ~r_d.status) != '0) |-> ((reg_we && reg_sel == SEL_STAT) || r_q.ctrl.rst))
        else $error("status bit cleared without a write");

    // R10: a paused channel issues no request
    assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> r_q.ctrl.run)
        else $error("request while run is clear");

    // R9: an interrupt needs a pending status bit
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.status != '0))
        else $error("interrupt without status");

endmodule

// File: tb/sim_adma_ring_channel.sv
module sim_adma_ring_channel;
    localparam logic [31:0] BASE_A = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        smp_strobe = 1'b0;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        irq;

    adma_ring_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_strobe(smp_strobe), .smp_valid(smp_valid), .smp_data(smp_data),
        .irq(irq)
    );

    always #10 clk = ~clk;

    logic [31:0] daddr [32];
    logic [31:0] dlen  [32];
    int          exp_q [$];
    int          checks = 0, errors = 0;
    int          s_checks = 0, s_errors = 0;
    logic        cons_en = 1'b1;
    logic        force_stb = 1'b0;
    int unsigned seed_v;

    function automatic logic [15:0] samp(input logic [31:0] b);
        return b[15:0] ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int idx;
        if (a >= BASE_A && a < BASE_A + 32'd256) begin
            idx = int'((a - BASE_A) >> 3);
            return a[2] ? dlen[idx] : daddr[idx];
        end
        return {samp({a[31:2], 2'b10}), samp({a[31:2], 2'b00})};
    endfunction

    // memory responder and sample consumer, away from the active edge
    always @(negedge clk) begin
        if (mem_req && ($urandom % 4 != 0)) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
        end else begin
            mem_ack = 1'b0;
        end
        smp_strobe = 1'b0;
        if (cons_en && smp_valid && ($urandom % 3 != 0)) begin
            smp_strobe = 1'b1;
            s_checks++;
            if (exp_q.size() == 0) begin
                s_errors++;
                $display("FAIL R3 sample order: act=%h exp=none", smp_data);
            end else begin
                if (smp_data !== exp_q[0][15:0]) begin
                    s_errors++;
                    $display("FAIL R3 sample order: act=%h exp=%h", smp_data, exp_q[0][15:0]);
                end
                void'(exp_q.pop_front());
            end
        end else if (force_stb) begin
            smp_strobe = 1'b1;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic add_desc(input int i);
        for (int k = 0; k < int'(dlen[i][15:0]); k++)
            exp_q.push_back(int'(samp(daddr[i] + 32'(2 * k))));
    endtask

    task automatic wait_status(input logic [2:0] mask, input int limit);
        logic [31:0] v;
        for (int t = 0; t < limit; t++) begin
            rd(3'd3, v);
            if ((v[2:0] & mask) == mask) break;
            tick();
        end
    endtask

    task automatic drain();
        for (int t = 0; t < 3000; t++) begin
            if (exp_q.size() == 0) break;
            tick();
        end
        chk("R3 all expected samples delivered", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog: act=hung exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks + s_checks + 1, errors + s_errors + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        exp_bc;
        int          prev, changes, bad, reqs;
        seed_v = $urandom(32'd4177);
        for (int i = 0; i < 32; i++) begin
            daddr[i] = 32'h0000_1000 + 32'(i) * 32'h40 + ((i % 2 == 1) ? 32'd2 : 32'd0);
            dlen[i]  = {($urandom % 2 == 1), 15'd0, 16'(1 + $urandom % 3)};
        end
        dlen[0] = {1'b0, 15'd0, 16'd4};
        dlen[1] = {1'b1, 15'd0, 16'd3};
        dlen[2] = {1'b0, 15'd0, 16'd0};
        dlen[3] = {1'b1, 15'd0, 16'd5};
        dlen[4] = {1'b0, 15'd0, 16'd2};

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            chk($sformatf("R1 register %0d after reset", s), v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
        chk("R1 smp_valid after reset", {31'd0, smp_valid}, 32'd0);

        // R13 base readback
        wr(3'd0, BASE_A);
        rd(3'd0, v);
        chk("R13 base readback", v, BASE_A);

        // R2 R3 R7 R5 R6: descriptors 0..3
        for (int i = 0; i < 4; i++) add_desc(i);
        wr(3'd2, 32'd3);
        rd(3'd2, v);
        chk("R13 last-valid readback", v, 32'd3);
        wr(3'd5, 32'h0F);
        wait_status(3'b100, 3000);
        drain();
        rd(3'd1, v);
        chk("R4 current index at last-valid", v, 32'd3);
        rd(3'd3, v);
        chk("R5 R6 status after run to last-valid", v, 32'd6);
        rd(3'd4, v);
        chk("R3 remaining count at end", v, 32'd0);
        chk("R9 irq with enabled status", {31'd0, irq}, 32'd1);
        reqs = 0;
        for (int t = 0; t < 20; t++) begin tick(); if (mem_req) reqs++; end
        chk("R6 no requests while halted", 32'(reqs), 32'd0);

        // R8 write-one-to-clear
        wr(3'd3, 32'd0);
        rd(3'd3, v);
        chk("R8 writing zeros keeps status", v, 32'd6);
        wr(3'd3, 32'd4);
        rd(3'd3, v);
        chk("R8 clear bit 2 only", v, 32'd2);
        wr(3'd3, 32'd2);
        rd(3'd3, v);
        chk("R8 clear bit 1", v, 32'd0);
        chk("R9 irq drops with status", {31'd0, irq}, 32'd0);

        // R5 no completion flag, R9 masked, R6 resume
        wr(3'd5, 32'h05);
        add_desc(4);
        wr(3'd2, 32'd4);
        wait_status(3'b100, 3000);
        drain();
        rd(3'd3, v);
        chk("R5 descriptor without flag sets only bit 2", v, 32'd4);
        chk("R9 irq masked when last-valid enable clear", {31'd0, irq}, 32'd0);
        rd(3'd1, v);
        chk("R6 resumed to next index", v, 32'd4);

        // R4 wrap past 31
        wr(3'd3, 32'd7);
        wr(3'd5, 32'h0F);
        exp_bc = 1'b0;
        for (int i = 5; i < 32; i++) begin add_desc(i); exp_bc = exp_bc | dlen[i][31]; end
        add_desc(0);
        wr(3'd2, 32'd0);
        prev = 4; changes = 0; bad = 0;
        for (int t = 0; t < 6000; t++) begin
            rd(3'd1, v);
            if (int'(v) != prev) begin
                if (int'(v) != (prev + 1) % 32) bad++;
                changes++;
                prev = int'(v);
            end
            if (changes >= 28) break;
            tick();
        end
        chk("R4 index changes around ring", 32'(changes), 32'd28);
        chk("R4 index steps by one", 32'(bad), 32'd0);
        wait_status(3'b100, 3000);
        drain();
        rd(3'd3, v);
        chk("R5 completion flag over wrap", v, {29'd0, 1'b1, exp_bc, 1'b0});
        rd(3'd1, v);
        chk("R4 index wrapped to 0", v, 32'd0);

        // R10 pause
        wr(3'd3, 32'd7);
        wr(3'd5, 32'h0E);
        wr(3'd2, 32'd2);
        reqs = 0;
        for (int t = 0; t < 30; t++) begin tick(); if (mem_req) reqs++; end
        chk("R10 no requests while paused", 32'(reqs), 32'd0);
        rd(3'd1, v);
        chk("R10 index held while paused", v, 32'd0);
        add_desc(1); add_desc(2);
        wr(3'd5, 32'h0F);
        wait_status(3'b100, 3000);
        drain();
        rd(3'd1, v);
        chk("R10 resumed to last-valid", v, 32'd2);

        // R11 underrun
        wr(3'd3, 32'd7);
        wr(3'd5, 32'h0E);
        force_stb = 1'b1; tick(); force_stb = 1'b0; tick();
        rd(3'd3, v);
        chk("R11 strobe with run clear ignored", v, 32'd0);
        wr(3'd5, 32'h0F);
        force_stb = 1'b1; tick(); force_stb = 1'b0; tick();
        rd(3'd3, v);
        chk("R11 underrun flag", v, 32'd1);
        chk("R9 irq on underrun", {31'd0, irq}, 32'd1);

        // R12 channel reset mid-stream
        wr(3'd3, 32'd7);
        cons_en = 1'b0;
        wr(3'd2, 32'd10);
        repeat (15) tick();
        wr(3'd5, 32'h10);
        tick(); tick();
        rd(3'd5, v);
        chk("R12 control cleared and reset bit self-cleared", v, 32'd0);
        rd(3'd1, v);
        chk("R12 current index cleared", v, 32'd0);
        rd(3'd2, v);
        chk("R12 last-valid cleared", v, 32'd0);
        rd(3'd3, v);
        chk("R12 status cleared", v, 32'd0);
        rd(3'd4, v);
        chk("R12 remaining cleared", v, 32'd0);
        chk("R12 held samples dropped", {31'd0, smp_valid}, 32'd0);
        chk("R12 irq low", {31'd0, irq}, 32'd0);
        rd(3'd0, v);
        chk("R13 base kept over channel reset", v, BASE_A);
        exp_q.delete();
        add_desc(0);
        cons_en = 1'b1;
        wr(3'd5, 32'h0F);
        wait_status(3'b100, 3000);
        drain();
        rd(3'd1, v);
        chk("R12 restart from index 0", v, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks + s_checks, errors + s_errors);
        $finish;
    end
endmodule